// File: doc/BRIEF.md
# Shifted Saturation Unit

This unit clamps a signed word into a programmable signed or unsigned range after an optional pre-shift. A source word is first shifted left (logical) or right (arithmetic) by a 5-bit amount. The result is read as a signed integer and compared against the bounds chosen by a width field `k`. Values above the upper bound become the upper bound. Values below the lower bound become the lower bound. Values inside the range pass through. Each clamped result raises a one-cycle pulse and sets a sticky overflow flag, which only a separate write port can clear.

A packed two-lane mode treats the word as two signed 16-bit halves. Each half is clamped on its own against a shared, narrower range, and the two results are packed back into one word. This mode applies no pre-shift. The unit is meant to sit in an execute stage beside the integer ALU. It takes one operation per cycle and returns its result one cycle later when the output register is enabled.

Top module: `shsat_unit`

## Requirements
- R1: With `is_signed`=1 and `dual_lane`=0, the allowed range is -(2^k) to 2^k-1, where k = `sat_width` (0 to 32). A pre-shifted value above 2^k-1 yields 2^k-1, a value below -(2^k) yields -(2^k), and any other value passes unchanged.
- R2: With `is_signed`=0 and `dual_lane`=0, the range is 0 to 2^k-1. The pre-shifted word is still read as signed 32-bit, so with k=32 the upper bound is 0xFFFFFFFF and a negative word clamps to 0.
- R3: Values of `sat_width` above 32 act as 32 in single-word mode.
- R4: `shift_kind`=0 shifts `src` left (logical) by `shift_amt`, keeping 32 bits. `shift_kind`=1 shifts it right (arithmetic) by `shift_amt`. An amount of 0 with `shift_kind`=1 means 32, which fills every bit with the sign bit.
- R5: With `dual_lane`=1, the pre-shift fields are ignored and k = `sat_width[3:0]`+1 (1 to 16). Signed `src[15:0]` is clamped and placed in result bits [15:0]. Signed `src[31:16]` is clamped and placed in bits [31:16]. The signed/unsigned ranges are those of R1 and R2.
- R6: `sat_pulse` is 1 together with a result exactly when that result clamped (either lane in two-lane mode). The flag `q_flag` is then 1 as well.
- R7: `q_flag` is sticky. `q_wr_en`=1 loads `q_wr_val`, but a clamping operation in the same cycle forces the flag to 1. Without a write, the flag never falls.
- R8: An operation presented with `in_valid`=1 appears on `result` with `out_valid`=1 one cycle later. Back-to-back operations are accepted every cycle, and `result` holds its value while no operation is presented.
- R9: While `rst_n` is low, `out_valid`, `sat_pulse`, `q_flag` and `result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| src | input | 32 | Source word |
| shift_kind | input | 1 | 0 logical left, 1 arithmetic right |
| shift_amt | input | 5 | Pre-shift amount |
| sat_width | input | 6 | Range exponent k |
| is_signed | input | 1 | 1 signed range, 0 unsigned range |
| dual_lane | input | 1 | Clamp two 16-bit halves independently |
| q_wr_en | input | 1 | Write the sticky flag |
| q_wr_val | input | 1 | Value written to the sticky flag |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Clamped word |
| sat_pulse | output | 1 | This result clamped |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The hardest case to reach is a flag write that lands in the same cycle as a clamping operation. The stimulus drives a clearing write alongside both a saturating and a non-saturating operation, then reads the flag on the next cycle. A second hard case is the pair of unsigned full-width and arithmetic shift-by-32 cases, where the sign of a 32-bit word decides the clamp. These are reached with all-ones and top-bit-only sources combined with `shift_amt`=0 and with `sat_width` values at and above 32.

// File: rtl/shsat_pkg.sv
package shsat_pkg;
  typedef enum logic {
    SH_LSL = 1'b0,
    SH_ASR = 1'b1
  } shift_kind_e;
endpackage

// File: rtl/shsat_preshift.sv
module shsat_preshift
  import shsat_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src,
  input  logic              kind,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] shifted
);
  localparam logic [AMT_W:0] FULL_AMT = (AMT_W+1)'(DATA_W);

  logic [AMT_W:0] amt_dec;

  // amount decode: zero on the arithmetic path means a full-width shift
  always_comb begin
    amt_dec = {1'b0, amt};
    if ((kind == SH_ASR) && (amt == '0)) begin
      amt_dec = FULL_AMT;
    end
  end

  always_comb begin
    if (kind == SH_LSL) begin
      if (amt_dec >= FULL_AMT) shifted = '0;
      else                     shifted = src << amt_dec;
    end else begin
      if (amt_dec >= FULL_AMT) shifted = {DATA_W{src[DATA_W-1]}};
      else                     shifted = DATA_W'($signed(src) >>> amt_dec);
    end
  end
endmodule

// File: rtl/shsat_clamp.sv
module shsat_clamp #(
  parameter int IN_W = 32,
  localparam int K_W = $clog2(IN_W) + 1
) (
  input  logic [IN_W-1:0] val,
  input  logic [K_W-1:0]  k,
  input  logic            sgn,
  output logic [IN_W-1:0] res,
  output logic            hit
);
  // two guard bits: one for 2^IN_W as a positive bound, one for sign
  localparam int CW = IN_W + 2;

  logic signed [CW-1:0] v_ext;
  logic signed [CW-1:0] pow_k;
  logic signed [CW-1:0] hi_b;
  logic signed [CW-1:0] lo_b;

  always_comb begin
    v_ext = {{2{val[IN_W-1]}}, val};
    pow_k = CW'(1) << k;
    hi_b  = pow_k - CW'(1);
    lo_b  = sgn ? -pow_k : '0;
  end

  always_comb begin
    hit = 1'b0;
    res = val;
    if (v_ext > hi_b) begin
      hit = 1'b1;
      res = hi_b[IN_W-1:0];
    end else if (v_ext < lo_b) begin
      hit = 1'b1;
      res = lo_b[IN_W-1:0];
    end
  end
endmodule

// File: rtl/shsat_qflag.sv
module shsat_qflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic wr_en,
  input  logic wr_val,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = wr_en ? wr_val : q;
    if (set) q_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end
endmodule

// File: rtl/shsat_unit.sv
module shsat_unit #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int KW     = $clog2(DATA_W) + 1,
  localparam int LANE_W = DATA_W / 2,
  localparam int LKW    = $clog2(LANE_W) + 1,
  localparam int LFW    = $clog2(LANE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] src,
  input  logic              shift_kind,
  input  logic [AMT_W-1:0]  shift_amt,
  input  logic [KW-1:0]     sat_width,
  input  logic              is_signed,
  input  logic              dual_lane,
  input  logic              q_wr_en,
  input  logic              q_wr_val,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              sat_pulse,
  output logic              q_flag
);
  localparam logic [KW-1:0] K_MAX = KW'(DATA_W);

  logic [DATA_W-1:0] shifted;
  logic [KW-1:0]     k_word;
  logic [LKW-1:0]    k_lane;
  logic [DATA_W-1:0] word_res;
  logic              word_hit;
  logic [DATA_W-1:0] lane_res;
  logic [1:0]        lane_hit;
  logic [DATA_W-1:0] res_d;
  logic              hit_d;

  shsat_preshift #(.DATA_W(DATA_W)) i_preshift (
    .src     (src),
    .kind    (shift_kind),
    .amt     (shift_amt),
    .shifted (shifted)
  );

  always_comb begin
    k_word = (sat_width > K_MAX) ? K_MAX : sat_width;
    k_lane = LKW'(sat_width[LFW-1:0]) + LKW'(1);
  end

  shsat_clamp #(.IN_W(DATA_W)) i_clamp_word (
    .val (shifted),
    .k   (k_word),
    .sgn (is_signed),
    .res (word_res),
    .hit (word_hit)
  );

  for (genvar g = 0; g < 2; g++) begin : g_lane
    shsat_clamp #(.IN_W(LANE_W)) i_clamp_lane (
      .val (src[g*LANE_W +: LANE_W]),
      .k   (k_lane),
      .sgn (is_signed),
      .res (lane_res[g*LANE_W +: LANE_W]),
      .hit (lane_hit[g])
    );
  end

  always_comb begin
    if (dual_lane) begin
      res_d = lane_res;
      hit_d = |lane_hit;
    end else begin
      res_d = word_res;
      hit_d = word_hit;
    end
  end

  shsat_qflag i_qflag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (in_valid & hit_d),
    .wr_en  (q_wr_en),
    .wr_val (q_wr_val),
    .q      (q_flag)
  );

  if (REG_OUT) begin : g_reg_out
    logic              vld_q;
    logic              pulse_q;
    logic [DATA_W-1:0] res_q;
    logic              pulse_n;

    always_comb pulse_n = in_valid & hit_d;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q   <= 1'b0;
        pulse_q <= 1'b0;
      end else begin
        vld_q   <= in_valid;
        pulse_q <= pulse_n;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        res_q <= '0;
      else if (in_valid) res_q <= res_d;
    end

    always_comb begin
      out_valid = vld_q;
      sat_pulse = pulse_q;
      result    = res_q;
    end
  end else begin : g_comb_out
    always_comb begin
      out_valid = in_valid;
      sat_pulse = in_valid & hit_d;
      result    = res_d;
    end
  end
endmodule

// File: rtl/shsat_unit_chk.sv
module shsat_unit_chk #(
  parameter int DATA_W  = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int KW     = $clog2(DATA_W) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [KW-1:0]     sat_width,
  input logic              is_signed,
  input logic              dual_lane,
  input logic              q_wr_en,
  input logic              q_wr_val,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              sat_pulse,
  input logic              q_flag
);
  if (REG_OUT) begin : g_props
    a_r7_q_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (q_flag && !q_wr_en) |=> q_flag);

    a_r7_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(q_wr_en && !q_wr_val) && !sat_pulse) |-> !q_flag);

    a_r6_pulse_sets_q: assert property (@(posedge clk) disable iff (!rst_n)
      sat_pulse |-> q_flag);

    a_r6_pulse_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      sat_pulse |-> out_valid);

    a_r2_unsigned_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(!is_signed && !dual_lane && sat_width == '0)) |-> (result == '0));

    a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> $stable(result));
  end
endmodule

bind shsat_unit shsat_unit_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .sat_width (sat_width),
  .is_signed (is_signed),
  .dual_lane (dual_lane),
  .q_wr_en   (q_wr_en),
  .q_wr_val  (q_wr_val),
  .out_valid (out_valid),
  .result    (result),
  .sat_pulse (sat_pulse),
  .q_flag    (q_flag)
);

// File: tb/test_shsat_unit.sv
`timescale 1ns/1ps
module test_shsat_unit;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] src;
  logic        shift_kind;
  logic [4:0]  shift_amt;
  logic [5:0]  sat_width;
  logic        is_signed;
  logic        dual_lane;
  logic        q_wr_en;
  logic        q_wr_val;
  logic        out_valid;
  logic [31:0] result;
  logic        sat_pulse;
  logic        q_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [31:0] res;
    logic        pulse;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [31:0] last_res;

  shsat_unit i_shsat_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
    .shift_kind(shift_kind), .shift_amt(shift_amt), .sat_width(sat_width),
    .is_signed(is_signed), .dual_lane(dual_lane), .q_wr_en(q_wr_en),
    .q_wr_val(q_wr_val), .out_valid(out_valid), .result(result),
    .sat_pulse(sat_pulse), .q_flag(q_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // clamp one signed value into the range given by k
  function automatic void clampv(input longint v, input int k, input logic sg,
                                 output longint r, output logic h);
    longint hi = (longint'(1) <<< k) - 1;
    longint lo = sg ? -(longint'(1) <<< k) : 0;
    h = 1'b0;
    r = v;
    if (v > hi) begin r = hi; h = 1'b1; end
    else if (v < lo) begin r = lo; h = 1'b1; end
  endfunction

  function automatic exp_t model(input logic [31:0] s, input logic kd, input logic [4:0] am,
                                 input logic [5:0] kw, input logic sg, input logic dl);
    exp_t e;
    longint v, r0, r1;
    logic h0, h1;
    logic [31:0] t;
    int k;
    if (dl) begin
      k = int'(kw[3:0]) + 1;
      clampv(longint'($signed(s[15:0])), k, sg, r0, h0);
      clampv(longint'($signed(s[31:16])), k, sg, r1, h1);
      e.res   = {r1[15:0], r0[15:0]};
      e.pulse = h0 | h1;
    end else begin
      if (kd == 1'b0) begin
        t = s << am;
        v = longint'($signed(t));
      end else begin
        v = longint'($signed(s)) >>> ((am == 0) ? 31 : int'(am));
      end
      k = (kw > 6'd32) ? 32 : int'(kw);
      clampv(v, k, sg, r0, h0);
      e.res   = r0[31:0];
      e.pulse = h0;
    end
    return e;
  endfunction

  task automatic fail_line(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    errors++;
    $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
  endtask

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) fail_line(tag, what, act, exp);
  endtask

  // driver: one operation per call, starting and ending on a falling edge
  task automatic op(input string tag, input logic [31:0] s, input logic kd,
                    input logic [4:0] am, input logic [5:0] kw, input logic sg,
                    input logic dl, input logic wen = 1'b0, input logic wv = 1'b0);
    exp_t e;
    e = model(s, kd, am, kw, sg, dl);
    e.tag = tag;
    sb.push_back(e);
    in_valid = 1'b1; src = s; shift_kind = kd; shift_amt = am;
    sat_width = kw; is_signed = sg; dual_lane = dl;
    q_wr_en = wen; q_wr_val = wv;
    @(negedge clk);
    in_valid = 1'b0; q_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic qwrite(input logic v);
    q_wr_en = 1'b1; q_wr_val = v;
    @(negedge clk);
    q_wr_en = 1'b0;
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        checks++;
        fail_line("R8", "unexpected out_valid", 32'(out_valid), 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "result", result, e.res);
        check(e.tag, "sat_pulse", 32'(sat_pulse), 32'(e.pulse));
        if (e.pulse) check("R6", "q_flag after clamp", 32'(q_flag), 32'd1);
        last_res = e.res;
      end
    end
  end

  task automatic report;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fail_line("WDOG", "watchdog expired", 32'd0, 32'd1);
      report();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; src = '0; shift_kind = 1'b0; shift_amt = '0;
    sat_width = '0; is_signed = 1'b0; dual_lane = 1'b0; q_wr_en = 1'b0; q_wr_val = 1'b0;
    idle(3);
    // R9: reset state
    check("R9", "out_valid in reset", 32'(out_valid), 32'd0);
    check("R9", "sat_pulse in reset", 32'(sat_pulse), 32'd0);
    check("R9", "q_flag in reset", 32'(q_flag), 32'd0);
    check("R9", "result in reset", result, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R1: signed ranges
    op("R1", 32'd100, 0, 0, 6'd7, 1, 0);
    check("R7", "q stays low without clamp", 32'(q_flag), 32'd0);
    op("R1", 32'd200, 0, 0, 6'd7, 1, 0);
    op("R1", -32'sd300, 0, 0, 6'd7, 1, 0);
    op("R1", -32'sd128, 0, 0, 6'd7, 1, 0);
    op("R1", 32'h7FFF_FFFF, 0, 0, 6'd31, 1, 0);
    op("R1", 32'h8000_0000, 0, 0, 6'd32, 1, 0);
    op("R1", 32'hFFFF_FFFF, 0, 0, 6'd0, 1, 0);
    op("R1", 32'd1, 0, 0, 6'd0, 1, 0);
    // R2: unsigned ranges
    op("R2", 32'd300, 0, 0, 6'd8, 0, 0);
    op("R2", -32'sd5, 0, 0, 6'd8, 0, 0);
    op("R2", 32'hFFFF_FFFF, 0, 0, 6'd32, 0, 0);
    op("R2", 32'h7FFF_FFFF, 0, 0, 6'd32, 0, 0);
    op("R2", 32'd9, 0, 0, 6'd0, 0, 0);
    // R3: width above 32
    op("R3", 32'h8000_0000, 0, 0, 6'd63, 1, 0);
    op("R3", 32'h7FFF_FFFF, 0, 0, 6'd40, 0, 0);
    op("R3", 32'hFFFF_FFFF, 0, 0, 6'd33, 0, 0);
    // R4: pre-shift
    op("R4", 32'h10, 0, 5'd4, 6'd15, 1, 0);
    op("R4", 32'hF, 0, 5'd28, 6'd20, 1, 0);
    op("R4", 32'h8000_0000, 1, 5'd4, 6'd31, 1, 0);
    op("R4", 32'h8000_0000, 1, 5'd0, 6'd8, 0, 0);
    op("R4", 32'h8000_0000, 1, 5'd0, 6'd3, 1, 0);
    op("R4", 32'h4000_0000, 1, 5'd0, 6'd2, 1, 0);
    op("R4", 32'h0001_0000, 1, 5'd8, 6'd8, 0, 0);
    // R5: two-lane mode, pre-shift fields must have no effect
    op("R5", 32'h7FFF_8000, 0, 0, 6'd7, 1, 1);
    op("R5", 32'h1234_FFFF, 0, 0, 6'd15, 0, 1);
    op("R5", 32'h0010_FFF0, 1, 5'd9, 6'd7, 1, 1);
    op("R5", 32'h8000_7FFF, 0, 5'd31, 6'd15, 1, 1);
    op("R5", 32'h0005_0002, 0, 0, 6'd0, 0, 1);
    idle(1);
    // R8: result holds while idle
    idle(2);
    check("R8", "result held while idle", result, last_res);
    check("R8", "out_valid low while idle", 32'(out_valid), 32'd0);

    // R7: sticky flag and writes
    check("R7", "q set after clamps", 32'(q_flag), 32'd1);
    qwrite(1'b0);
    check("R7", "q cleared by write", 32'(q_flag), 32'd0);
    op("R7", 32'd5, 0, 0, 6'd7, 1, 0);
    check("R7", "q low after passing op", 32'(q_flag), 32'd0);
    qwrite(1'b1);
    check("R7", "q set by write", 32'(q_flag), 32'd1);
    idle(3);
    check("R7", "q sticky while idle", 32'(q_flag), 32'd1);
    op("R7", 32'd500, 0, 0, 6'd4, 1, 0, 1'b1, 1'b0);
    check("R7", "clamp beats clearing write", 32'(q_flag), 32'd1);
    op("R7", 32'd3, 0, 0, 6'd4, 1, 0, 1'b1, 1'b0);
    check("R7", "clear with passing op", 32'(q_flag), 32'd0);
    idle(2);

    checks++;
    if (sb.size() != 0) fail_line("R8", "results missing", 32'(sb.size()), 32'd0);
    done = 1;
    report();
  end
endmodule